// File: doc/BRIEF.md
# Split-Accumulator Multiply-Accumulate Unit

This execution unit sits in the integer pipeline of a 32-bit processor. It handles a multiply-accumulate operation that takes two general registers but multiplies only their low halves. The result is a 32-bit product, formed in either signed or unsigned mode. The product is added to a 40-bit running sum. That sum is not one register. Its top byte lives in the low eight bits of one 32-bit host register, and its low 32 bits form a second register. Software can read and write both registers directly, in the same way as any other architectural register. Each operation also returns the low word of the new sum as a write to a destination general register.

The unit can accept one operation every clock. The multiply is registered first and the accumulate happens in the following stage. The destination result therefore appears two clocks after issue. Consecutive operations still chain through the sum without a gap. The pipeline presents the source register numbers of the instruction now being issued. If that instruction needs the destination of the operation issued one clock earlier, the unit holds it for one cycle.

Top module: `mac40_unit`

## Requirements
- R1: Only bits [15:0] of each source operand reach the multiplier. Changing bits [31:16] of either operand changes no result.
- R2: When `mac_signed` is 1, the two low halves are multiplied as two's-complement numbers and the 32-bit product is sign-extended to 40 bits. When it is 0, they are multiplied as unsigned numbers and the product is zero-extended.
- R3: Each accepted operation replaces the 40-bit sum S = {host[7:0], low} with (S + extended product) mod 2^40. Bits [39:32] of the new sum go to host bits [7:0], and bits [31:0] go to the low register. No flag marks a wrap.
- R4: For each accepted operation, `res_data` carries bits [31:0] of the new sum and `res_rd` carries the destination number given at issue.
- R5: `res_valid` is high exactly in the cycle after the second rising edge that follows an accepted issue. Operations accepted on consecutive clocks each add to the sum left by the one before.
- R6: `stall_req` is high while an operation accepted on the previous edge has destination d, and some source slot i of the presented instruction has `dec_src_used[i]`=1 and `dec_src_addr[i]`=d. Slot i occupies bits [5i+4:5i] of `dec_src_addr`. A slot whose used bit is 0 never causes a stall. The stall lasts exactly one cycle.
- R7: An operation presented while `stall_req` is high is not accepted. It must be presented again, and it is accepted on the following edge.
- R8: `accr_rd_data` shows the low register when `accr_rd_sel`=0 and the full 32-bit host register when it is 1. A write with `accr_wr_en`=1 replaces the selected register on the next edge, using the same select encoding.
- R9: An accumulate never alters host bits [31:8]. Only a direct write to the host register changes them.
- R10: When a direct write and an accumulate update land on the same edge, the register that is written takes the written value. The other register takes its accumulate value.
- R11: A synchronous active-high `rst` clears both registers, the operation in flight and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mac_valid | input | 1 | A multiply-accumulate operation is presented for issue |
| mac_signed | input | 1 | 1 = signed multiply, 0 = unsigned multiply |
| mac_op_a | input | 32 | First source operand; only bits [15:0] are used |
| mac_op_b | input | 32 | Second source operand; only bits [15:0] are used |
| mac_rd | input | 5 | Destination general register number |
| dec_src_addr | input | 10 | Source register numbers of the presented instruction, 5 bits per slot |
| dec_src_used | input | 2 | Per-slot flag: that source is actually read |
| stall_req | output | 1 | Hold the presented instruction for this cycle |
| res_valid | output | 1 | Destination write is valid |
| res_rd | output | 5 | Destination register number |
| res_data | output | 32 | Low word of the new sum |
| accr_wr_en | input | 1 | Direct write to an accumulator register |
| accr_wr_sel | input | 1 | Write target: 0 = low register, 1 = host register |
| accr_wr_data | input | 32 | Direct write data |
| accr_rd_sel | input | 1 | Read target: 0 = low register, 1 = host register |
| accr_rd_data | output | 32 | Selected register value |

## Verification
The bench builds the unit with its default parameters: 32-bit registers, 16-bit multiply halves, an 8-bit upper field, 5-bit register numbers and two source slots. With these values the whole 40-bit sum can be reached. Direct writes can preload the upper byte to 0xFF and the low word to near all-ones. That makes both the carry wrap through bit 39 and the borrow from a negative signed product reachable in a few operations. With source numbers drawn from a small range, random traffic regularly hits the one-cycle interlock through each of the two slots.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
   typedef enum logic {
      ACC_SEL_LO = 1'b0,
      ACC_SEL_HI = 1'b1
   } acc_sel_e;

   function automatic logic [7:0] clog_min1(input int n);
      int v;
      v = 1;
      while ((1 << v) < n) v++;
      return v[7:0];
   endfunction
endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
   parameter int XLEN = 32,
   parameter int OPW  = 16,
   localparam int PW  = 2 * OPW
) (
   input  logic            is_signed,
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   output logic [PW-1:0]   prod
);
   logic signed [OPW:0]    ext_a;
   logic signed [OPW:0]    ext_b;
   logic signed [PW+1:0]   full;

   generate
      if (OPW > XLEN) begin : g_bad_opw
         $error("mac40_mult: OPW must not exceed XLEN");
      end
   endgenerate

   always_comb begin
      ext_a = {is_signed & op_a[OPW-1], op_a[OPW-1:0]};
      ext_b = {is_signed & op_b[OPW-1], op_b[OPW-1:0]};
      full  = ext_a * ext_b;
      prod  = full[PW-1:0];
   end
endmodule

// File: rtl/mac40_hazard.sv
module mac40_hazard #(
   parameter int RAW  = 5,
   parameter int NSRC = 2
) (
   input  logic                pend_vld,
   input  logic [RAW-1:0]      pend_rd,
   input  logic [NSRC*RAW-1:0] src_addr,
   input  logic [NSRC-1:0]     src_used,
   output logic                stall
);
   logic [NSRC-1:0] hit;

   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("mac40_hazard: NSRC must be at least 1");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_slot
         assign hit[i] = src_used[i] && (src_addr[i*RAW +: RAW] == pend_rd);
      end
   endgenerate

   assign stall = pend_vld && (|hit);
endmodule

// File: rtl/mac40_acc.sv
module mac40_acc
   import mac40_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int HIW  = 8,
   parameter int PW   = 32,
   localparam int ACCW = HIW + XLEN
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            upd_vld,
   input  logic            upd_sgn,
   input  logic [PW-1:0]   upd_prod,
   input  logic            wr_en,
   input  acc_sel_e        wr_sel,
   input  logic [XLEN-1:0] wr_data,
   input  acc_sel_e        rd_sel,
   output logic [XLEN-1:0] rd_data,
   output logic [XLEN-1:0] sum_lo
);
   logic [XLEN-1:0] host_q;
   logic [XLEN-1:0] low_q;
   logic [ACCW-1:0] prod_ext;
   logic [ACCW-1:0] sum;

   generate
      if (HIW > XLEN) begin : g_bad_hiw
         $error("mac40_acc: HIW must fit inside the host register");
      end
      if (PW > ACCW) begin : g_bad_pw
         $error("mac40_acc: product wider than accumulator");
      end
      if (HIW == XLEN) begin : g_full_host
         always_ff @(posedge clk) begin
            if (rst) host_q <= '0;
            else if (wr_en && wr_sel == ACC_SEL_HI) host_q <= wr_data;
            else if (upd_vld) host_q <= sum[ACCW-1:XLEN];
         end
      end else begin : g_part_host
         always_ff @(posedge clk) begin
            if (rst) host_q <= '0;
            else if (wr_en && wr_sel == ACC_SEL_HI) host_q <= wr_data;
            else if (upd_vld) host_q[HIW-1:0] <= sum[ACCW-1:XLEN];
         end
      end
   endgenerate

   always_comb begin
      prod_ext = {{(ACCW-PW){upd_sgn & upd_prod[PW-1]}}, upd_prod};
      sum      = {host_q[HIW-1:0], low_q} + prod_ext;
      sum_lo   = sum[XLEN-1:0];
      rd_data  = (rd_sel == ACC_SEL_HI) ? host_q : low_q;
   end

   always_ff @(posedge clk) begin
      if (rst) low_q <= '0;
      else if (wr_en && wr_sel == ACC_SEL_LO) low_q <= wr_data;
      else if (upd_vld) low_q <= sum[XLEN-1:0];
   end

   AST_HOST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_sel == ACC_SEL_HI) |=> $stable(host_q[XLEN-1:HIW])); // R9
   AST_LOW_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == ACC_SEL_LO) |=> low_q == $past(wr_data)); // R10
   AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (upd_vld && !wr_en) |=> {host_q[HIW-1:0], low_q} == $past(sum)); // R3
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
   import mac40_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int OPW  = 16,
   parameter int HIW  = 8,
   parameter int RAW  = 5,
   parameter int NSRC = 2,
   localparam int PW  = 2 * OPW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mac_valid,
   input  logic                mac_signed,
   input  logic [XLEN-1:0]     mac_op_a,
   input  logic [XLEN-1:0]     mac_op_b,
   input  logic [RAW-1:0]      mac_rd,
   input  logic [NSRC*RAW-1:0] dec_src_addr,
   input  logic [NSRC-1:0]     dec_src_used,
   output logic                stall_req,
   output logic                res_valid,
   output logic [RAW-1:0]      res_rd,
   output logic [XLEN-1:0]     res_data,
   input  logic                accr_wr_en,
   input  logic                accr_wr_sel,
   input  logic [XLEN-1:0]     accr_wr_data,
   input  logic                accr_rd_sel,
   output logic [XLEN-1:0]     accr_rd_data
);
   logic            take;
   logic [PW-1:0]   prod_d;
   logic            e1_vld;
   logic            e1_sgn;
   logic [RAW-1:0]  e1_rd;
   logic [PW-1:0]   e1_prod;
   logic [XLEN-1:0] sum_lo;
   acc_sel_e        wr_sel_e;
   acc_sel_e        rd_sel_e;

   generate
      if (PW > XLEN) begin : g_bad_pw
         $error("mac40_unit: product must fit a register");
      end
   endgenerate

   assign wr_sel_e = acc_sel_e'(accr_wr_sel);
   assign rd_sel_e = acc_sel_e'(accr_rd_sel);
   assign take     = mac_valid && !stall_req;

   mac40_mult #(.XLEN(XLEN), .OPW(OPW)) u_mult (
      .is_signed (mac_signed),
      .op_a      (mac_op_a),
      .op_b      (mac_op_b),
      .prod      (prod_d)
   );

   mac40_hazard #(.RAW(RAW), .NSRC(NSRC)) u_hazard (
      .pend_vld (e1_vld),
      .pend_rd  (e1_rd),
      .src_addr (dec_src_addr),
      .src_used (dec_src_used),
      .stall    (stall_req)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         e1_vld  <= 1'b0;
         e1_sgn  <= 1'b0;
         e1_rd   <= '0;
         e1_prod <= '0;
      end else begin
         e1_vld <= take;
         if (take) begin
            e1_sgn  <= mac_signed;
            e1_rd   <= mac_rd;
            e1_prod <= prod_d;
         end
      end
   end

   mac40_acc #(.XLEN(XLEN), .HIW(HIW), .PW(PW)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .upd_vld  (e1_vld),
      .upd_sgn  (e1_sgn),
      .upd_prod (e1_prod),
      .wr_en    (accr_wr_en),
      .wr_sel   (wr_sel_e),
      .wr_data  (accr_wr_data),
      .rd_sel   (rd_sel_e),
      .rd_data  (accr_rd_data),
      .sum_lo   (sum_lo)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_rd    <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= e1_vld;
         if (e1_vld) begin
            res_rd   <= e1_rd;
            res_data <= sum_lo;
         end
      end
   end

   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      stall_req |=> !stall_req); // R6
   AST_STALL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (rst)
      stall_req |=> !e1_vld); // R7
   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (mac_valid && !stall_req) |-> ##2 res_valid); // R5
   AST_RESULT_RD: assert property (@(posedge clk) disable iff (rst)
      (mac_valid && !stall_req) |=> e1_rd == $past(mac_rd)); // R4
endmodule

// File: tb/tb_mac40_unit.sv
module tb_mac40_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mac_valid = 0, mac_signed = 0;
   logic [31:0] mac_op_a = 0, mac_op_b = 0;
   logic [4:0]  mac_rd = 0;
   logic [9:0]  dec_src_addr = 0;
   logic [1:0]  dec_src_used = 0;
   logic        stall_req, res_valid;
   logic [4:0]  res_rd;
   logic [31:0] res_data;
   logic        accr_wr_en = 0, accr_wr_sel = 0, accr_rd_sel = 0;
   logic [31:0] accr_wr_data = 0;
   logic [31:0] accr_rd_data;

   int nchk = 0, nbad = 0;
   bit done = 0;
   string cur_tag = "R11";

   logic [31:0] m_lo, m_hi, m_e1p, m_wbd;
   logic        m_e1v, m_e1s, m_wbv, exp_stall;
   logic [4:0]  m_e1rd, m_wbrd;

   mac40_unit dut (.*);

   always #5 clk = ~clk;

   function automatic logic [31:0] ref_prod(logic [31:0] a, logic [31:0] b, logic s);
      int sa, sb;
      if (s) begin
         sa = int'($signed(a[15:0]));
         sb = int'($signed(b[15:0]));
         return 32'(sa * sb);
      end
      return {16'h0, a[15:0]} * {16'h0, b[15:0]};
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_lo = 0; m_hi = 0; m_e1v = 0; m_e1s = 0; m_e1p = 0; m_e1rd = 0;
      m_wbv = 0; m_wbd = 0; m_wbrd = 0;
   endtask

   // Called just after a negedge once inputs are set; returns at the next negedge.
   task automatic cyc();
      logic [39:0] acc;
      logic take;
      #1;
      exp_stall = m_e1v && ((dec_src_used[0] && dec_src_addr[4:0] == m_e1rd) ||
                            (dec_src_used[1] && dec_src_addr[9:5] == m_e1rd));
      chk("stall", {31'b0, stall_req}, {31'b0, exp_stall});
      take = mac_valid && !exp_stall;
      @(posedge clk);
      m_wbv = m_e1v;
      if (m_e1v) begin
         acc = {m_hi[7:0], m_lo} + {{8{m_e1s & m_e1p[31]}}, m_e1p};
         m_hi[7:0] = acc[39:32];
         m_lo = acc[31:0];
         m_wbd = acc[31:0];
         m_wbrd = m_e1rd;
      end
      if (accr_wr_en) begin
         if (accr_wr_sel) m_hi = accr_wr_data;
         else m_lo = accr_wr_data;
      end
      m_e1v = take;
      if (take) begin
         m_e1s = mac_signed;
         m_e1p = ref_prod(mac_op_a, mac_op_b, mac_signed);
         m_e1rd = mac_rd;
      end
      @(negedge clk);
      chk("res_valid", {31'b0, res_valid}, {31'b0, m_wbv});
      if (m_wbv) begin
         chk("res_data", res_data, m_wbd);
         chk("res_rd", {27'b0, res_rd}, {27'b0, m_wbrd});
      end
      chk("acc_read", accr_rd_data, accr_rd_sel ? m_hi : m_lo);
   endtask

   task automatic idle();
      mac_valid = 0; dec_src_used = 0; accr_wr_en = 0;
   endtask

   task automatic mac(logic s, logic [31:0] a, logic [31:0] b, logic [4:0] rd);
      mac_valid = 1; mac_signed = s; mac_op_a = a; mac_op_b = b; mac_rd = rd;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(negedge clk);
      rst = 0;
      // R11: reset state
      cur_tag = "R11";
      idle(); accr_rd_sel = 0; cyc();
      accr_rd_sel = 1; cyc();
      // R1: upper operand bits ignored (unsigned 0xFFFF*0x0003)
      cur_tag = "R1";
      mac(0, 32'hDEAD_FFFF, 32'h7777_0003, 5'd3); cyc();
      mac(0, 32'h0000_FFFF, 32'h0000_0003, 5'd4); cyc();
      idle(); accr_rd_sel = 0; cyc(); cyc();
      // R2: signed -1 * -1 adds 1; signed -2 * 3 subtracts 6
      cur_tag = "R2";
      mac(1, 32'h1234_FFFF, 32'h0000_FFFF, 5'd5); cyc();
      mac(1, 32'h0000_FFFE, 32'hFFFF_0003, 5'd6); cyc();
      idle(); cyc(); cyc();
      // R6: hazard via slot 0, slot 1, unused slot
      cur_tag = "R6";
      mac(0, 2, 3, 5'd7); cyc();
      idle(); dec_src_addr = {5'd1, 5'd7}; dec_src_used = 2'b01; cyc(); cyc();
      mac(0, 2, 3, 5'd9); cyc();
      idle(); dec_src_addr = {5'd9, 5'd2}; dec_src_used = 2'b10; cyc(); cyc();
      mac(0, 2, 3, 5'd11); cyc();
      idle(); dec_src_addr = {5'd11, 5'd11}; dec_src_used = 2'b00; cyc(); cyc();
      // R7: dependent MAC held one cycle, then accepted
      cur_tag = "R7";
      mac(0, 5, 5, 5'd12); dec_src_used = 0; cyc();
      mac(0, 1, 1, 5'd13); dec_src_addr = {5'd0, 5'd12}; dec_src_used = 2'b01; cyc();
      cyc();
      idle(); cyc(); cyc();
      // R9/R3: preload near wrap, host upper bits kept
      cur_tag = "R9";
      accr_wr_en = 1; accr_wr_sel = 1; accr_wr_data = 32'hABCD_EFFF; cyc();
      accr_wr_sel = 0; accr_wr_data = 32'hFFFF_FFF0; cyc();
      accr_wr_en = 0; accr_rd_sel = 1;
      mac(0, 32'h20, 1, 5'd14); cyc();
      idle(); cyc(); cyc();
      cur_tag = "R3";
      mac(1, 32'hFFFF, 32'h1, 5'd15); cyc();
      idle(); cyc(); accr_rd_sel = 0; cyc();
      // R10: direct write on the same edge as the accumulate update
      cur_tag = "R10";
      mac(0, 100, 100, 5'd16); cyc();
      mac_valid = 0; accr_wr_en = 1; accr_wr_sel = 0; accr_wr_data = 32'h5555_0000; cyc();
      accr_wr_en = 0; cyc(); accr_rd_sel = 1; cyc();
      // R5/R8: back-to-back chain
      cur_tag = "R5";
      for (int i = 0; i < 6; i++) begin
         mac(i[0], 32'h100 + i, 32'h8000 + i, 5'(i)); cyc();
      end
      idle(); cyc(); cyc();
      cur_tag = "R8";
      accr_wr_en = 1; accr_wr_sel = 0; accr_wr_data = 32'h0BAD_F00D; cyc();
      accr_wr_en = 0; accr_rd_sel = 0; cyc();
      // R4/R3: constrained random traffic
      cur_tag = "R4";
      for (int n = 0; n < 4000; n++) begin
         mac_valid = ($urandom() % 4) != 0;
         mac_signed = $urandom() % 2;
         mac_op_a = $urandom(); mac_op_b = $urandom();
         mac_rd = 5'($urandom() % 6);
         dec_src_addr = {5'($urandom() % 6), 5'($urandom() % 6)};
         dec_src_used = 2'($urandom());
         accr_wr_en = ($urandom() % 16) == 0;
         accr_wr_sel = $urandom() % 2;
         accr_wr_data = ($urandom() % 2) ? 32'hFFFF_FFF8 : $urandom();
         accr_rd_sel = $urandom() % 2;
         cyc();
      end
      idle(); cyc(); cyc();
      done = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule